// File: doc/BRIEF.md
# Score, level and on-screen digit writer

This block keeps the running score and the best score of a falling-block puzzle game. Each cleared line adds ten points. A new-game pulse folds the finished score into the best score and then clears the running score. The block also derives a two-bit gravity speed code from the score, so the game speeds up as points build.

Both numbers are held as packed BCD digits. They reach the screen through a write port into a 32-column by 16-row character buffer that stores 8-bit codes. After every change, a short sequencer writes the digit characters of both numbers at fixed buffer positions, one character per clock. The buffer and the glyph renderer that reads it live outside this block.

Top module: `score_text_unit`

## Requirements
- R1: After reset, `wr_en` is low and `speed` is 0. The running score and the best score are both zero, which the first refresh shows as four `0x30` characters on each row.
- R2: A `line_clr` pulse with `new_game` low adds 10 to the running score. The score is held as four BCD digits, most significant first.
- R3: `speed` is 0 for a score below 100, 1 for 100 to 199, 2 for 200 to 299 and 3 for 300 or more. The code is the level number minus one. Without `new_game`, `speed` never falls.
- R4: `new_game` clears the running score, so `speed` is 0 from the next cycle. When `new_game` and `line_clr` are high in the same cycle, `new_game` wins and no points are added.
- R5: On `new_game`, the best score takes the running score only if the running score is strictly larger. Otherwise the best score keeps its value. Line clears never change the best score.
- R6: A score change starts a refresh in the next cycle: exactly 8 consecutive cycles with `wr_en` high. The first four writes go to row 8, columns 12 to 15, running-score digits most significant first. The next four go to row 7, the same columns, with the best-score digits. The address is column in `wr_col` (5 bits) and row in `wr_row` (4 bits). `wr_en` is high at no other time.
- R7: Each written character is `0x30` plus the BCD digit value.
- R8: A score change during a refresh restarts the sequence from row 8, column 12 in the next cycle.
- R9: At a score of 9990, a further `line_clr` is ignored: the score stays unchanged and no refresh starts.
- R10: Every `new_game` starts a refresh, even when the running score is already zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_game | input | 1 | One-cycle pulse: a new game begins |
| line_clr | input | 1 | One-cycle pulse: one line was cleared |
| speed | output | 2 | Gravity speed code, level minus one |
| wr_en | output | 1 | Character buffer write enable |
| wr_char | output | 8 | Character code to write |
| wr_col | output | 5 | Buffer column address |
| wr_row | output | 4 | Buffer row address |

## Verification
A wrong digit or a broken carry in the score register shows up as wrong characters on row 8 within eight cycles of the next line clear. It also shows up on `speed` as soon as the hundreds digit moves. A best-score register that updates at the wrong time only shows on row 7, and only on the refresh after a `new_game`. The bench therefore compares both rows after every game boundary. A sequencer fault shows in the cycle right after the triggering pulse: a write that starts late, a write count other than eight, or a restart that fails to return to column 12.

// File: rtl/score_pkg.sv
package score_pkg;

    typedef logic [3:0] bcd_t;

    // one decimal digit after a conditional increment, plus its carry
    typedef struct packed {
        logic carry;
        bcd_t dig;
    } bcd_step_t;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_RUN  = 1'b1
    } wr_state_e;

    localparam bcd_t BCD_NINE = 4'd9;

    function automatic bcd_step_t bcd_inc(input bcd_t d, input logic en);
        bcd_step_t r;
        if (!en) begin
            r.carry = 1'b0;
            r.dig   = d;
        end else if (d == BCD_NINE) begin
            r.carry = 1'b1;
            r.dig   = '0;
        end else begin
            r.carry = 1'b0;
            r.dig   = d + 4'd1;
        end
        return r;
    endfunction

    // hundreds digit plus "anything above hundreds" -> 2-bit speed code
    function automatic logic [1:0] level_of(input bcd_t hund, input logic upper_nz);
        logic [1:0] lv;
        if (upper_nz || hund >= 4'd3) lv = 2'd3;
        else                          lv = hund[1:0];
        return lv;
    endfunction

    function automatic logic [7:0] digit_char(input bcd_t d, input logic [7:0] base);
        return base + {4'd0, d};
    endfunction

endpackage

// File: rtl/bcd_score_reg.sv
module bcd_score_reg
    import score_pkg::*;
#(
    parameter int DIGITS    = 4,
    parameter int PTS_DIGIT = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  add,
    output logic [4*DIGITS-1:0]   value,
    output logic                  changed
);
    logic [DIGITS:0]        cin;
    logic [4*DIGITS-1:0]    cand;
    logic                   overflow;

    generate
        if (PTS_DIGIT == 0) begin : g_c0_add
            assign cin[0] = add;
        end else begin : g_c0_zero
            assign cin[0] = 1'b0;
        end

        for (genvar i = 0; i < DIGITS; i++) begin : g_dig
            bcd_step_t s;
            assign s = bcd_inc(value[4*i +: 4], cin[i]);
            assign cand[4*i +: 4] = s.dig;
            if (i + 1 == PTS_DIGIT) begin : g_inject
                assign cin[i+1] = s.carry | add;
            end else begin : g_chain
                assign cin[i+1] = s.carry;
            end
        end
    endgenerate

    assign overflow = cin[DIGITS];
    assign changed  = clr | (add & ~overflow);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (add && !overflow) begin
            value <= cand;
        end
    end
endmodule

// File: rtl/best_score_reg.sv
module best_score_reg #(
    parameter int DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic [4*DIGITS-1:0] cur,
    output logic [4*DIGITS-1:0] best
);
    // packed BCD compares like the decimal number it encodes
    always_ff @(posedge clk) begin
        if (rst) begin
            best <= '0;
        end else if (take && (cur > best)) begin
            best <= cur;
        end
    end
endmodule

// File: rtl/digit_writer.sv
module digit_writer
    import score_pkg::*;
#(
    parameter int DIGITS    = 4,
    parameter int COL_W     = 5,
    parameter int ROW_W     = 4,
    parameter int SCORE_ROW = 8,
    parameter int TOP_ROW   = 7,
    parameter int FIRST_COL = 12,
    parameter logic [7:0] CHAR_BASE = 8'h30
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [4*DIGITS-1:0] score,
    input  logic [4*DIGITS-1:0] best,
    output logic                wr_en,
    output logic [7:0]          wr_char,
    output logic [COL_W-1:0]    wr_col,
    output logic [ROW_W-1:0]    wr_row
);
    localparam int SEQ_LEN = 2 * DIGITS;
    localparam int IDX_W   = $clog2(SEQ_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);
    localparam logic [IDX_W-1:0] DIG_CNT  = IDX_W'(DIGITS);

    wr_state_e           st;
    logic [IDX_W-1:0]    idx;
    logic                on_top;
    logic [IDX_W-1:0]    pos;
    logic [4*DIGITS-1:0] src;
    bcd_t                dig;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= WR_IDLE;
            idx <= '0;
        end else if (start) begin
            st  <= WR_RUN;
            idx <= '0;
        end else if (st == WR_RUN) begin
            if (idx == LAST_IDX) begin
                st  <= WR_IDLE;
                idx <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        on_top  = (idx >= DIG_CNT);
        pos     = on_top ? (idx - DIG_CNT) : idx;
        src     = on_top ? best : score;
        dig     = bcd_t'(src >> (4 * (DIGITS - 1 - int'(pos))));
        wr_en   = (st == WR_RUN);
        wr_char = digit_char(dig, CHAR_BASE);
        wr_row  = on_top ? ROW_W'(TOP_ROW) : ROW_W'(SCORE_ROW);
        wr_col  = COL_W'(FIRST_COL) + COL_W'(pos);
    end
endmodule

// File: rtl/score_text_unit.sv
module score_text_unit
    import score_pkg::*;
#(
    parameter int DIGITS    = 4,
    parameter int PTS_DIGIT = 1,
    parameter int TEXT_COLS = 32,
    parameter int TEXT_ROWS = 16,
    parameter int SCORE_ROW = 8,
    parameter int TOP_ROW   = 7,
    parameter int FIRST_COL = 12,
    parameter logic [7:0] CHAR_BASE = 8'h30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       new_game,
    input  logic       line_clr,
    output logic [1:0] speed,
    output logic       wr_en,
    output logic [7:0] wr_char,
    output logic [4:0] wr_col,
    output logic [3:0] wr_row
);
    localparam int COL_W = $clog2(TEXT_COLS);
    localparam int ROW_W = $clog2(TEXT_ROWS);
    localparam int HUND  = 2;

    logic [4*DIGITS-1:0] score_q;
    logic [4*DIGITS-1:0] best_q;
    logic                score_chg;
    logic                add_pts;
    logic                upper_nz;
    logic [COL_W-1:0]    col_w;
    logic [ROW_W-1:0]    row_w;

    assign add_pts = line_clr & ~new_game;

    bcd_score_reg #(
        .DIGITS   (DIGITS),
        .PTS_DIGIT(PTS_DIGIT)
    ) u_score (
        .clk    (clk),
        .rst    (rst),
        .clr    (new_game),
        .add    (add_pts),
        .value  (score_q),
        .changed(score_chg)
    );

    best_score_reg #(
        .DIGITS(DIGITS)
    ) u_best (
        .clk (clk),
        .rst (rst),
        .take(new_game),
        .cur (score_q),
        .best(best_q)
    );

    generate
        if (DIGITS > HUND + 1) begin : g_upper
            assign upper_nz = |score_q[4*DIGITS-1:4*(HUND+1)];
        end else begin : g_no_upper
            assign upper_nz = 1'b0;
        end
    endgenerate

    assign speed = level_of(score_q[4*HUND +: 4], upper_nz);

    digit_writer #(
        .DIGITS   (DIGITS),
        .COL_W    (COL_W),
        .ROW_W    (ROW_W),
        .SCORE_ROW(SCORE_ROW),
        .TOP_ROW  (TOP_ROW),
        .FIRST_COL(FIRST_COL),
        .CHAR_BASE(CHAR_BASE)
    ) u_writer (
        .clk    (clk),
        .rst    (rst),
        .start  (score_chg),
        .score  (score_q),
        .best   (best_q),
        .wr_en  (wr_en),
        .wr_char(wr_char),
        .wr_col (col_w),
        .wr_row (row_w)
    );

    assign wr_col = 5'(col_w);
    assign wr_row = 4'(row_w);
endmodule

// File: rtl/score_text_chk.sv
module score_text_chk #(
    parameter int SCORE_ROW = 8,
    parameter int TOP_ROW   = 7,
    parameter int FIRST_COL = 12,
    parameter logic [7:0] CHAR_BASE = 8'h30
) (
    input logic       clk,
    input logic       rst,
    input logic       new_game,
    input logic       line_clr,
    input logic [1:0] speed,
    input logic       wr_en,
    input logic [7:0] wr_char,
    input logic [4:0] wr_col,
    input logic [3:0] wr_row
);
    assert_row_valid_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_row == 4'(SCORE_ROW) || wr_row == 4'(TOP_ROW)));

    assert_col_step_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !line_clr && !new_game) |=>
            (!wr_en || wr_col == $past(wr_col) + 5'd1 || wr_col == 5'(FIRST_COL)));

    assert_char_digit_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_char >= CHAR_BASE && wr_char <= CHAR_BASE + 8'd9));

    assert_speed_mono_R3: assert property (@(posedge clk) disable iff (rst)
        !new_game |=> speed >= $past(speed));

    assert_clear_speed_R4: assert property (@(posedge clk) disable iff (rst)
        new_game |=> speed == 2'd0);

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        new_game |=> (wr_en && wr_row == 4'(SCORE_ROW) && wr_col == 5'(FIRST_COL)));
endmodule

bind score_text_unit score_text_chk #(
    .SCORE_ROW(SCORE_ROW),
    .TOP_ROW  (TOP_ROW),
    .FIRST_COL(FIRST_COL),
    .CHAR_BASE(CHAR_BASE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .new_game(new_game),
    .line_clr(line_clr),
    .speed   (speed),
    .wr_en   (wr_en),
    .wr_char (wr_char),
    .wr_col  (wr_col),
    .wr_row  (wr_row)
);

// File: tb/tb_score_text_unit.sv
module tb_score_text_unit;
    localparam int SROW = 8;
    localparam int TROW = 7;
    localparam int FCOL = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       new_game = 1'b0;
    logic       line_clr = 1'b0;
    logic [1:0] speed;
    logic       wr_en;
    logic [7:0] wr_char;
    logic [4:0] wr_col;
    logic [3:0] wr_row;

    int errors = 0;
    int checks = 0;
    int wr_count = 0;
    int log_n = 0;
    int log_row [16];
    int log_col [16];
    logic [7:0] shadow [16][32];

    // vector table: lines to add, expected score, expected speed code
    localparam int VN = 6;
    localparam int V_LINES [VN] = '{3, 7, 9, 1, 10, 70};
    localparam int V_SCORE [VN] = '{30, 100, 190, 200, 300, 1000};
    localparam int V_SPEED [VN] = '{0, 1, 1, 2, 3, 3};

    score_text_unit dut (
        .clk(clk), .rst(rst), .new_game(new_game), .line_clr(line_clr),
        .speed(speed), .wr_en(wr_en), .wr_char(wr_char),
        .wr_col(wr_col), .wr_row(wr_row)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!rst && wr_en) begin
            shadow[wr_row][wr_col] = wr_char;
            wr_count++;
            if (log_n < 16) begin
                log_row[log_n] = int'(wr_row);
                log_col[log_n] = int'(wr_col);
                log_n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int shown(input int row);
        int v = 0;
        for (int i = 0; i < 4; i++) begin
            if (shadow[row][FCOL+i] < 8'h30 || shadow[row][FCOL+i] > 8'h39) return -1;
            v = v * 10 + int'(shadow[row][FCOL+i] - 8'h30);
        end
        return v;
    endfunction

    function automatic int exp_speed(input int s);
        if (s < 100) return 0;
        if (s < 200) return 1;
        if (s < 300) return 2;
        return 3;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic add_line();
        @(negedge clk) line_clr = 1'b1;
        @(negedge clk) line_clr = 1'b0;
        idle(9);
    endtask

    task automatic start_game(input bit with_line);
        @(negedge clk) begin new_game = 1'b1; line_clr = with_line; end
        @(negedge clk) begin new_game = 1'b0; line_clr = 1'b0; end
        idle(9);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 32; c++) shadow[r][c] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        idle(4);
        check(wr_en == 1'b0, "R1 wr_en low", int'(wr_en), 0);
        check(speed == 2'd0, "R1 speed", int'(speed), 0);
        check(wr_count == 0, "R1 no writes", wr_count, 0);

        // R10, R6: new_game refresh with zero score
        wr_count = 0; log_n = 0;
        start_game(1'b0);
        check(wr_count == 8, "R10 write count", wr_count, 8);
        for (int k = 0; k < 8; k++) begin
            check(log_row[k] == ((k < 4) ? SROW : TROW), "R6 order row", log_row[k], (k < 4) ? SROW : TROW);
            check(log_col[k] == FCOL + (k % 4), "R6 order col", log_col[k], FCOL + (k % 4));
        end
        check(shown(SROW) == 0, "R1 score zero", shown(SROW), 0);
        check(shown(TROW) == 0, "R1 best zero", shown(TROW), 0);

        // R2, R3, R7: vector table walk
        for (int v = 0; v < VN; v++) begin
            for (int n = 0; n < V_LINES[v]; n++) add_line();
            check(shown(SROW) == V_SCORE[v], "R2 score", shown(SROW), V_SCORE[v]);
            check(int'(speed) == V_SPEED[v], "R3 speed", int'(speed), V_SPEED[v]);
            check(V_SPEED[v] == exp_speed(V_SCORE[v]), "R3 table", V_SPEED[v], exp_speed(V_SCORE[v]));
        end
        check(shown(TROW) == 0, "R5 best unchanged mid-game", shown(TROW), 0);

        // R6 timing: first write in the cycle after the pulse
        wr_count = 0;
        @(negedge clk) line_clr = 1'b1;
        @(negedge clk) line_clr = 1'b0;
        check(wr_en == 1'b1, "R6 first write timing", int'(wr_en), 1);
        check(wr_row == 4'(SROW) && wr_col == 5'(FCOL), "R6 first address", int'(wr_col), FCOL);
        idle(9);
        check(wr_count == 8, "R6 write count", wr_count, 8);
        check(shown(SROW) == 1010, "R2 score 1010", shown(SROW), 1010);

        // R8 restart during refresh
        wr_count = 0;
        @(negedge clk) line_clr = 1'b1;
        @(negedge clk) line_clr = 1'b0;
        @(negedge clk);
        @(negedge clk) line_clr = 1'b1;
        @(negedge clk) begin
            line_clr = 1'b0;
            check(wr_row == 4'(SROW) && wr_col == 5'(FCOL), "R8 restart address", int'(wr_col), FCOL);
        end
        idle(10);
        check(wr_count == 11, "R8 write count", wr_count, 11);
        check(shown(SROW) == 1030, "R8 score", shown(SROW), 1030);

        // R4 new_game beats line_clr, R5 best takes larger score
        start_game(1'b1);
        check(shown(SROW) == 0, "R4 score cleared", shown(SROW), 0);
        check(speed == 2'd0, "R4 speed", int'(speed), 0);
        check(shown(TROW) == 1030, "R5 best updated", shown(TROW), 1030);

        for (int n = 0; n < 5; n++) add_line();
        check(shown(SROW) == 50, "R2 score 50", shown(SROW), 50);
        start_game(1'b0);
        check(shown(TROW) == 1030, "R5 best kept", shown(TROW), 1030);

        // R9 saturation
        for (int n = 0; n < 999; n++) begin
            @(negedge clk) line_clr = 1'b1;
            @(negedge clk) line_clr = 1'b0;
        end
        idle(10);
        check(shown(SROW) == 9990, "R9 score 9990", shown(SROW), 9990);
        check(speed == 2'd3, "R3 speed top", int'(speed), 3);
        wr_count = 0;
        add_line();
        check(wr_count == 0, "R9 no refresh", wr_count, 0);
        check(speed == 2'd3, "R9 speed held", int'(speed), 3);
        start_game(1'b0);
        check(shown(TROW) == 9990, "R5 best 9990 (score held)", shown(TROW), 9990);

        // R10 new_game with score already zero
        wr_count = 0;
        start_game(1'b0);
        check(wr_count == 8, "R10 refresh at zero", wr_count, 8);
        check(shown(TROW) == 9990, "R5 best after zero game", shown(TROW), 9990);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule